// File: doc/BRIEF.md
# Indexed Effective Address Unit with Bounds Check

This block forms the effective address of an operand. The instruction supplies an address field and a 4-bit index selector. When the selector is non-zero, the value held in the chosen index register is added to the address field. The sum is truncated to the address width. The result is then compared with a programmable lower and upper limit, and an address that falls outside that window raises a protection-violation flag in the same cycle that the address is presented.

The unit holds sixteen index registers. A separate port loads and reads them. A read returns its data one clock after the request. A write is a two-clock operation, and `busy` is high during its second clock. While `busy` is high, the unit accepts no lookups and no reads, so the requester must hold its request. Selector value zero never applies an index, even though register zero exists and can be written and read. The two limits are loaded through their own write strobes.

Top module: `eau_top`

## Requirements
- R1: A lookup with selector 0 yields an effective address equal to the 18-bit address field, whatever index register 0 holds.
- R2: A lookup with selector 1..15 yields the low 18 bits of the sum of the zero-extended address field and the 24-bit index register, and any carry above bit 17 is dropped.
- R3: `ea_valid` is high exactly one clock after a cycle with `req_valid` high and `busy` low, and a lookup presented while `busy` is high produces no `ea_valid`.
- R4: A write is accepted when `idx_wr_en` is high and `busy` is low. `busy` is then high for exactly the following clock, and the new value is used by lookups and reads accepted from the clock after that. A write presented while `busy` is high is ignored.
- R5: A read with `idx_rd_en` high and `busy` low returns the selected register on `idx_rd_data`, with `idx_rd_valid` high one clock later. A read presented while `busy` is high produces no `idx_rd_valid`.
- R6: `ea_viol` is high together with `ea_valid` exactly when the effective address is below the lower limit or above the upper limit. Both limits are inclusive.
- R7: After reset the lower limit is 0 and the upper limit is 2^18-1. A limit write takes effect for lookups accepted on the following clock, and a limit with no write keeps its value.
- R8: During and right after reset, `busy`, `ea_valid`, `ea_viol` and `idx_rd_valid` are low.
- R9: Index register 0 can be written and read back through the read port like any other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr_en | input | 1 | Index register write request |
| idx_wr_sel | input | 4 | Index register to write |
| idx_wr_data | input | 24 | Value to write |
| idx_rd_en | input | 1 | Index register read request |
| idx_rd_sel | input | 4 | Index register to read |
| idx_rd_data | output | 24 | Read result |
| idx_rd_valid | output | 1 | Read result valid |
| lim_lo_wr | input | 1 | Load lower limit |
| lim_hi_wr | input | 1 | Load upper limit |
| lim_wr_data | input | 18 | Limit value |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 18 | Instruction address field |
| req_sel | input | 4 | Index selector, 0 = no indexing |
| ea_out | output | 18 | Effective address |
| ea_valid | output | 1 | Effective address valid |
| ea_viol | output | 1 | Effective address outside limits |
| busy | output | 1 | Write in progress; lookups and reads not accepted |

## Verification
Lookups are tried with selector zero while register 0 holds a non-zero value, which separates true bypass from an ordinary indexed add. Address fields near the top of the range, paired with large index values, show whether the carry is dropped correctly. Addresses placed one below, at, and one above each limit tell inclusive comparison apart from exclusive comparison. Writes, reads and lookups are issued back to back and in the same cycle, which shows whether the busy stall and the write-to-use timing hold. A long mixed random stream is also compared against the reference model on every clock.

// File: rtl/eau_pkg.sv
package eau_pkg;
  localparam int EAU_NUM_IDX = 16;
  localparam int EAU_IDX_W   = 24;
  localparam int EAU_ADDR_W  = 18;

  typedef enum logic [0:0] {
    WR_IDLE   = 1'b0,
    WR_COMMIT = 1'b1
  } wr_state_e;
endpackage

// File: rtl/eau_index_file.sv
module eau_index_file
  import eau_pkg::*;
#(
  parameter int NUM   = EAU_NUM_IDX,
  parameter int DW    = EAU_IDX_W,
  localparam int SW   = $clog2(NUM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] lk_sel,
  output logic [DW-1:0] lk_data,
  input  logic [SW-1:0] rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          busy
);
  wr_state_e     state_q;
  logic [SW-1:0] pend_sel_q;
  logic [DW-1:0] pend_data_q;
  logic [DW-1:0] regs [NUM];

  assign busy = (state_q == WR_COMMIT);

  // two-clock write: capture, then commit
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WR_IDLE;
    end else if (state_q == WR_COMMIT) begin
      state_q <= WR_IDLE;
    end else if (wr_en) begin
      state_q <= WR_COMMIT;
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == WR_IDLE && wr_en) begin
      pend_sel_q  <= wr_sel;
      pend_data_q <= wr_data;
    end
  end

  // storage without reset so distributed RAM can be inferred
  always_ff @(posedge clk) begin
    if (state_q == WR_COMMIT) regs[pend_sel_q] <= pend_data_q;
  end

  assign lk_data = regs[lk_sel];
  assign rd_data = regs[rd_sel];

  assert_write_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> busy);
  assert_single_busy_R4: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);
endmodule

// File: rtl/eau_addr_calc.sv
module eau_addr_calc
  import eau_pkg::*;
#(
  parameter int AW   = EAU_ADDR_W,
  parameter int DW   = EAU_IDX_W,
  parameter int SW   = 4,
  localparam int PAD = DW - AW
) (
  input  logic [AW-1:0] addr,
  input  logic [SW-1:0] sel,
  input  logic [DW-1:0] idx_val,
  output logic [AW-1:0] ea
);
  logic [DW-1:0] addr_ext;
  logic [DW-1:0] sum;

  generate
    if (PAD > 0) begin : g_pad
      assign addr_ext = {{PAD{1'b0}}, addr};
    end else begin : g_nopad
      assign addr_ext = addr;
    end
  endgenerate

  assign sum = addr_ext + idx_val;

  always_comb begin
    if (sel == '0) ea = addr;
    else           ea = sum[AW-1:0];
  end

  initial begin
    assert_width_ok_R2: assert (DW >= AW);
  end
endmodule

// File: rtl/eau_bound_check.sv
module eau_bound_check
  import eau_pkg::*;
#(
  parameter int AW = EAU_ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lo_wr,
  input  logic          hi_wr,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] ea,
  output logic          viol
);
  logic [AW-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '1;
    end else begin
      if (lo_wr) lo_q <= wr_data;
      if (hi_wr) hi_q <= wr_data;
    end
  end

  assign viol = (ea < lo_q) || (ea > hi_q);

  assert_lo_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !lo_wr |=> $stable(lo_q));
  assert_hi_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> $stable(hi_q));
endmodule

// File: rtl/eau_top.sv
module eau_top
  import eau_pkg::*;
#(
  parameter int NUM_IDX = EAU_NUM_IDX,
  parameter int IDX_W   = EAU_IDX_W,
  parameter int ADDR_W  = EAU_ADDR_W,
  localparam int SEL_W  = $clog2(NUM_IDX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_wr_en,
  input  logic [SEL_W-1:0]  idx_wr_sel,
  input  logic [IDX_W-1:0]  idx_wr_data,
  input  logic              idx_rd_en,
  input  logic [SEL_W-1:0]  idx_rd_sel,
  output logic [IDX_W-1:0]  idx_rd_data,
  output logic              idx_rd_valid,
  input  logic              lim_lo_wr,
  input  logic              lim_hi_wr,
  input  logic [ADDR_W-1:0] lim_wr_data,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEL_W-1:0]  req_sel,
  output logic [ADDR_W-1:0] ea_out,
  output logic              ea_valid,
  output logic              ea_viol,
  output logic              busy
);
  logic [IDX_W-1:0]  lk_data, rd_data_c;
  logic [ADDR_W-1:0] ea_c;
  logic              viol_c;
  logic              busy_c;
  logic              lk_take, rd_take;

  eau_index_file #(.NUM(NUM_IDX), .DW(IDX_W)) u_file (
    .clk(clk), .rst(rst),
    .wr_en(idx_wr_en), .wr_sel(idx_wr_sel), .wr_data(idx_wr_data),
    .lk_sel(req_sel), .lk_data(lk_data),
    .rd_sel(idx_rd_sel), .rd_data(rd_data_c),
    .busy(busy_c)
  );

  eau_addr_calc #(.AW(ADDR_W), .DW(IDX_W), .SW(SEL_W)) u_calc (
    .addr(req_addr), .sel(req_sel), .idx_val(lk_data), .ea(ea_c)
  );

  eau_bound_check #(.AW(ADDR_W)) u_bound (
    .clk(clk), .rst(rst),
    .lo_wr(lim_lo_wr), .hi_wr(lim_hi_wr), .wr_data(lim_wr_data),
    .ea(ea_c), .viol(viol_c)
  );

  assign lk_take = req_valid && !busy_c;
  assign rd_take = idx_rd_en && !busy_c;
  assign busy    = busy_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid     <= 1'b0;
      ea_viol      <= 1'b0;
      idx_rd_valid <= 1'b0;
    end else begin
      ea_valid     <= lk_take;
      ea_viol      <= lk_take && viol_c;
      idx_rd_valid <= rd_take;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_take) ea_out      <= ea_c;
    if (rd_take) idx_rd_data <= rd_data_c;
  end

  assert_ea_accept_R3: assert property (@(posedge clk) disable iff (rst)
    ea_valid |-> ($past(req_valid) && !$past(busy)));
  assert_rd_accept_R5: assert property (@(posedge clk) disable iff (rst)
    idx_rd_valid |-> ($past(idx_rd_en) && !$past(busy)));
  assert_sel0_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_sel == '0) |=> (ea_out == $past(req_addr)));
  assert_viol_qual_R6: assert property (@(posedge clk) disable iff (rst)
    ea_viol |-> ea_valid);
endmodule

// File: tb/eau_top_test.sv
`timescale 1ns/1ps
module eau_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idx_wr_en = 0;
  logic [3:0]  idx_wr_sel = 0;
  logic [23:0] idx_wr_data = 0;
  logic        idx_rd_en = 0;
  logic [3:0]  idx_rd_sel = 0;
  logic [23:0] idx_rd_data;
  logic        idx_rd_valid;
  logic        lim_lo_wr = 0, lim_hi_wr = 0;
  logic [17:0] lim_wr_data = 0;
  logic        req_valid = 0;
  logic [17:0] req_addr = 0;
  logic [3:0]  req_sel = 0;
  logic [17:0] ea_out;
  logic        ea_valid, ea_viol, busy;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eau_top uut (.*);

  // reference model state
  logic [23:0] m_idx [16];
  int          m_lo, m_hi;
  bit          m_busy;
  int          m_psel;
  logic [23:0] m_pdata;
  bit          e_ea_v, e_rd_v, e_viol;
  int          e_ea;
  logic [23:0] e_rd;
  string       tag_ea, tag_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; e_ea_v = 0; e_rd_v = 0; e_viol = 0;
      m_lo = 0; m_hi = 262143;   // R7 reset limits
    end else begin
      e_ea_v = req_valid && !m_busy;
      if (e_ea_v) begin
        if (req_sel == 0) begin e_ea = req_addr; tag_ea = "R1"; end
        else begin
          e_ea = (int'(req_addr) + int'(m_idx[req_sel])) % 262144;
          tag_ea = "R2";
        end
        e_viol = (e_ea < m_lo) || (e_ea > m_hi);
      end else e_viol = 0;
      e_rd_v = idx_rd_en && !m_busy;
      if (e_rd_v) begin
        e_rd = m_idx[idx_rd_sel];
        tag_rd = (idx_rd_sel == 0) ? "R9" : "R5";
      end
      if (m_busy) begin m_idx[m_psel] = m_pdata; m_busy = 0; end
      else if (idx_wr_en) begin
        m_psel = idx_wr_sel; m_pdata = idx_wr_data; m_busy = 1;
      end
      if (lim_lo_wr) m_lo = lim_wr_data;
      if (lim_hi_wr) m_hi = lim_wr_data;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        chk(busy == 0 && ea_valid == 0 && idx_rd_valid == 0 && ea_viol == 0, "R8 reset",
            {busy, ea_valid, idx_rd_valid, ea_viol}, 0);
      end else begin
        chk(busy == m_busy, "R4 busy", busy, m_busy);
        chk(ea_valid == e_ea_v, "R3 ea_valid", ea_valid, e_ea_v);
        chk(idx_rd_valid == e_rd_v, "R5 rd_valid", idx_rd_valid, e_rd_v);
        if (e_ea_v) begin
          chk(ea_out == e_ea[17:0], tag_ea, ea_out, e_ea);
          chk(ea_viol == e_viol, "R6/R7 viol", ea_viol, e_viol);
        end
        if (e_rd_v) chk(idx_rd_data == e_rd, tag_rd, idx_rd_data, e_rd);
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    idx_wr_en = 0; idx_rd_en = 0; req_valid = 0; lim_lo_wr = 0; lim_hi_wr = 0;
  endtask

  task automatic wr(input int s, input logic [23:0] d);
    idle(); idx_wr_en = 1; idx_wr_sel = 4'(s); idx_wr_data = d;
    idle();
  endtask

  task automatic rd(input int s);
    idle(); idx_rd_en = 1; idx_rd_sel = 4'(s);
  endtask

  task automatic look(input int a, input int s);
    idle(); req_valid = 1; req_addr = 18'(a); req_sel = 4'(s);
  endtask

  task automatic lim(input bit hi, input int v);
    idle(); lim_lo_wr = !hi; lim_hi_wr = hi; lim_wr_data = 18'(v);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 16; i++) wr(i, 24'(i * 24'h1111 + 3));
    idle();
    for (int i = 0; i < 16; i++) rd(i);           // R5, R9
    look(18'h00123, 0);                            // R1 reg0 nonzero
    look(18'h3FFFF, 1);                            // R2 carry dropped
    wr(7, 24'hFFFFFF);
    look(18'h00010, 7);                            // R2 wraps to 0x0F
    // busy stall: write then lookup/read during busy
    idle(); idx_wr_en = 1; idx_wr_sel = 4'd3; idx_wr_data = 24'h000100;
    idle(); req_valid = 1; req_addr = 18'h5; req_sel = 4'd3;   // R3 dropped
    idx_rd_en = 1; idx_rd_sel = 4'd3;                         // R5 dropped
    idx_wr_en = 1; idx_wr_sel = 4'd4;                         // R4 ignored
    idle(); req_valid = 1; req_addr = 18'h5; req_sel = 4'd3;   // R4 new value
    rd(4);
    // limits, inclusive edges (R6, R7)
    lim(0, 100); lim(1, 200);
    look(99, 0); look(100, 0); look(200, 0); look(201, 0);
    // limit write and lookup in same cycle: old limit used
    idle(); lim_lo_wr = 1; lim_wr_data = 18'd150; req_valid = 1; req_addr = 18'd120; req_sel = 0;
    look(120, 0);
    // mixed random stream
    for (int n = 0; n < 3000; n++) begin
      idle();
      idx_wr_en = ($urandom % 6) == 0; idx_wr_sel = 4'($urandom); idx_wr_data = 24'($urandom);
      idx_rd_en = $urandom % 2; idx_rd_sel = 4'($urandom);
      req_valid = ($urandom % 4) != 0; req_addr = 18'($urandom); req_sel = 4'($urandom);
      lim_lo_wr = ($urandom % 40) == 0; lim_hi_wr = ($urandom % 40) == 0;
      lim_wr_data = 18'($urandom);
    end
    idle(); idle(); idle();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule